// File: doc/BRIEF.md
# Backplane Slave Select and Acknowledge

This block is the bus-facing front end of a peripheral card that sits on an asynchronous backplane with separate address and data strobes. It compares the top byte of the address bus with a card select code. Five bits of that code come from configuration inputs and three are fixed in a parameter. The compare result is qualified with the address strobe to form an active-low card-addressed signal. That signal also enables the card's drivers onto the backplane.

While the card is addressed, either data strobe starts a transfer. A two-stage flip-flop chain, clocked by the system clock, returns an active-low transfer acknowledge on the second rising edge. The chain is cleared at once, with no clock edge needed, when the address is withdrawn.

The low address lines select the operation inside the card. The top line of that group flags an analog read. When that flag is low, the three lowest lines pick one of eight register-select strobes. Two lines carry a gain code, which passes through two register stages before it reaches the gain output.

Top module: `bp_slave_front`

## Requirements
- R1: `card_sel_n` is low exactly when `as_n` is low and `addr_hi[4:0]` equals `sel_code` and `addr_hi[7:5]` equals the parameter `FIXED_BITS` (default 3'b010).
- R2: A difference in any of the fixed bits `addr_hi[7:5]` keeps `card_sel_n` high, even when the switch bits match and `as_n` is low.
- R3: `card_sel_oe` and `dtack_oe` are both high exactly while the card is addressed (`card_sel_n` low), and both are low otherwise.
- R4: While the card is addressed and a data strobe (`uds_n` or `lds_n`, either one alone) is low, `dtack_n` is still high after the first rising clock edge and is low after the second.
- R5: While the card is addressed with both data strobes high, `dtack_n` stays high on every clock edge.
- R6: When the address is removed, `dtack_n` returns high at once, with no clock edge. A new access again needs two rising edges before `dtack_n` goes low.
- R7: `ana_rd` is high exactly when the card is addressed and `addr_lo[5]` is high. `addr_lo[0]` maps to the lowest operation line.
- R8: `reg_sel` is one-hot with bit `addr_lo[2:0]` set when the card is addressed, a data strobe is low and `ana_rd` is low. In every other case `reg_sel` is all zero.
- R9: `gain` shows the value of `addr_lo[4:3]` that was present at the second-to-last rising edge, provided the card was addressed at that edge. Edges where the card is not addressed do not load a new gain.
- R10: The synchronous active-high reset `rst` leaves `dtack_n` high and `gain` zero after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_hi | input | 8 | Upper address byte (A16 upward) |
| sel_code | input | 5 | Configurable select-code bits |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| addr_lo | input | 6 | Operation address lines (A1 upward) |
| card_sel_n | output | 1 | Card addressed, active low |
| card_sel_oe | output | 1 | Drive enable for card_sel_n |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| dtack_oe | output | 1 | Drive enable for dtack_n |
| ana_rd | output | 1 | Analog read in progress |
| reg_sel | output | 8 | One-hot register-select strobes |
| gain | output | 2 | Registered gain code |

## Verification
The hardest case to reach from the ports is the clear of the acknowledge chain that happens between clock edges. Address withdrawal has to be seen releasing `dtack_n` without any edge. After that, a new access has to be seen paying the full two-edge latency again and not reusing leftover state. The bench changes `as_n` half a period away from the rising edge and samples `dtack_n` before the next edge. It then re-addresses the card and samples after the first edge, where `dtack_n` must still be high. The gain pipeline is driven the same way, with the gain lines changed while the card is deselected, to show that those edges load nothing.

// File: rtl/bp_front_pkg.sv
package bp_front_pkg;
  // One-hot expansion of a small binary index
  function automatic logic [7:0] onehot8(input logic [2:0] idx);
    logic [7:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/bp_card_match.sv
module bp_card_match #(
  parameter int HI_W  = 8,
  parameter int SW_W  = 5,
  parameter logic [HI_W-SW_W-1:0] FIXED_BITS = 3'b010
) (
  input  logic [HI_W-1:0] addr_hi,
  input  logic [SW_W-1:0] sel_code,
  input  logic            as_n,
  output logic            addressed
);
  localparam int FX_W = HI_W - SW_W;

  logic [HI_W-1:0] expect_code;
  assign expect_code = {FIXED_BITS[FX_W-1:0], sel_code};

  always_comb addressed = (addr_hi == expect_code) && !as_n;
endmodule

// File: rtl/bp_ack_chain.sv
module bp_ack_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic xfer,
  output logic ack
);
  logic [STAGES-1:0] sh;

  // Cleared as soon as the transfer qualifier drops; advances on clk otherwise
  always_ff @(posedge clk or negedge xfer) begin
    if (!xfer)    sh <= '0;
    else if (rst) sh <= '0;
    else          sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign ack = sh[STAGES-1];
endmodule

// File: rtl/bp_op_decode.sv
module bp_op_decode
  import bp_front_pkg::*;
#(
  parameter int LO_W     = 6,
  parameter int G_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            addressed,
  input  logic            xfer,
  input  logic [LO_W-1:0] addr_lo,
  output logic            ana_rd,
  output logic [7:0]      reg_sel,
  output logic [1:0]      gain
);
  localparam int RD_BIT = LO_W - 1;
  localparam int G_LSB  = 3;

  always_comb begin
    ana_rd  = addressed && addr_lo[RD_BIT];
    reg_sel = (xfer && !ana_rd) ? onehot8(addr_lo[2:0]) : '0;
  end

  logic [1:0] g_q [G_STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < G_STAGES; gi++) begin : g_pipe
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst)            g_q[0] <= '0;
          else if (addressed) g_q[0] <= addr_lo[G_LSB+1:G_LSB];
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) g_q[gi] <= '0;
          else     g_q[gi] <= g_q[gi-1];
        end
      end
    end
  endgenerate

  assign gain = g_q[G_STAGES-1];
endmodule

// File: rtl/bp_slave_front.sv
module bp_slave_front #(
  parameter int HI_W = 8,
  parameter int SW_W = 5,
  parameter logic [HI_W-SW_W-1:0] FIXED_BITS = 3'b010,
  parameter int LO_W = 6,
  parameter int ACK_STAGES = 2,
  parameter int G_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HI_W-1:0] addr_hi,
  input  logic [SW_W-1:0] sel_code,
  input  logic            as_n,
  input  logic            uds_n,
  input  logic            lds_n,
  input  logic [LO_W-1:0] addr_lo,
  output logic            card_sel_n,
  output logic            card_sel_oe,
  output logic            dtack_n,
  output logic            dtack_oe,
  output logic            ana_rd,
  output logic [7:0]      reg_sel,
  output logic [1:0]      gain
);
  logic addressed, xfer, ack;

  bp_card_match #(.HI_W(HI_W), .SW_W(SW_W), .FIXED_BITS(FIXED_BITS)) u_match (
    .addr_hi(addr_hi), .sel_code(sel_code), .as_n(as_n), .addressed(addressed)
  );

  assign xfer = addressed && (!uds_n || !lds_n);

  bp_ack_chain #(.STAGES(ACK_STAGES)) u_ack (
    .clk(clk), .rst(rst), .xfer(xfer), .ack(ack)
  );

  bp_op_decode #(.LO_W(LO_W), .G_STAGES(G_STAGES)) u_dec (
    .clk(clk), .rst(rst), .addressed(addressed), .xfer(xfer),
    .addr_lo(addr_lo), .ana_rd(ana_rd), .reg_sel(reg_sel), .gain(gain)
  );

  assign card_sel_n  = !addressed;
  assign card_sel_oe = addressed;
  assign dtack_n     = !ack;
  assign dtack_oe    = addressed;
endmodule

// File: rtl/bp_slave_front_chk.sv
module bp_slave_front_chk #(
  parameter int HI_W = 8,
  parameter int SW_W = 5,
  parameter logic [HI_W-SW_W-1:0] FIXED_BITS = 3'b010,
  parameter int LO_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [HI_W-1:0] addr_hi,
  input logic [SW_W-1:0] sel_code,
  input logic            as_n,
  input logic            uds_n,
  input logic            lds_n,
  input logic [LO_W-1:0] addr_lo,
  input logic            card_sel_n,
  input logic            card_sel_oe,
  input logic            dtack_n,
  input logic            dtack_oe,
  input logic            ana_rd,
  input logic [7:0]      reg_sel,
  input logic [1:0]      gain
);
  logic hit;
  assign hit = !as_n && (addr_hi == {FIXED_BITS, sel_code});

  p_select_r1: assert property (@(posedge clk) disable iff (rst) hit |-> !card_sel_n);
  p_fixed_r2:  assert property (@(posedge clk) disable iff (rst)
                 (addr_hi[HI_W-1:SW_W] != FIXED_BITS) |-> card_sel_n);
  p_drive_r3:  assert property (@(posedge clk) disable iff (rst)
                 (card_sel_oe == !card_sel_n) && (dtack_oe == card_sel_oe));
  p_ackpath_r4: assert property (@(posedge clk) disable iff (rst)
                 !dtack_n |-> $past(!card_sel_n && (!uds_n || !lds_n)));
  p_nostrobe_r5: assert property (@(posedge clk) disable iff (rst)
                 (uds_n && lds_n) |-> dtack_n);
  p_release_r6: assert property (@(posedge clk) disable iff (rst) card_sel_n |-> dtack_n);
  p_anard_r7:  assert property (@(posedge clk) disable iff (rst) ana_rd |-> !card_sel_n);
  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
                 $onehot0(reg_sel) && (ana_rd ? (reg_sel == '0) : 1'b1));
  p_gain_r9:   assert property (@(posedge clk) disable iff (rst)
                 ($past(!rst, 2) && $past(!rst, 1) && $past(!card_sel_n, 2))
                 |-> (gain == $past(addr_lo[4:3], 2)));
  p_reset_r10: assert property (@(posedge clk) rst |=> (dtack_n && gain == 2'b00));
endmodule

bind bp_slave_front bp_slave_front_chk #(
  .HI_W(HI_W), .SW_W(SW_W), .FIXED_BITS(FIXED_BITS), .LO_W(LO_W)
) u_chk (.*);

// File: tb/bp_slave_front_tb.sv
module bp_slave_front_tb;
  localparam int CLK_P = 10;
  localparam logic [2:0] FIX = 3'b010;

  logic clk = 0, rst = 1;
  logic [7:0] addr_hi = '0;
  logic [4:0] sel_code = 5'b10110;
  logic as_n = 1, uds_n = 1, lds_n = 1;
  logic [5:0] addr_lo = '0;
  logic card_sel_n, card_sel_oe, dtack_n, dtack_oe, ana_rd;
  logic [7:0] reg_sel;
  logic [1:0] gain;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  bp_slave_front u_dut (
    .clk(clk), .rst(rst), .addr_hi(addr_hi), .sel_code(sel_code), .as_n(as_n),
    .uds_n(uds_n), .lds_n(lds_n), .addr_lo(addr_lo), .card_sel_n(card_sel_n),
    .card_sel_oe(card_sel_oe), .dtack_n(dtack_n), .dtack_oe(dtack_oe),
    .ana_rd(ana_rd), .reg_sel(reg_sel), .gain(gain)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1; as_n = 1; uds_n = 1; lds_n = 1;
    after_edge();
    chk("R10 dtack_n", dtack_n, 1);
    chk("R10 gain", gain, 0);
    chk("R10 card_sel_n", card_sel_n, 1);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_match();
    @(negedge clk); addr_hi = {FIX, sel_code}; as_n = 0; #1;
    chk("R1 match", card_sel_n, 0);
    chk("R3 sel oe", card_sel_oe, 1);
    chk("R3 dtack oe", dtack_oe, 1);
    addr_hi[2] = ~addr_hi[2]; #1;
    chk("R1 switch bit differs", card_sel_n, 1);
    chk("R3 oe released", card_sel_oe, 0);
    addr_hi = {FIX ^ 3'b100, sel_code}; #1;
    chk("R2 fixed bit differs", card_sel_n, 1);
    addr_hi = {FIX, sel_code}; as_n = 1; #1;
    chk("R1 strobe high", card_sel_n, 1);
    chk("R3 dtack oe released", dtack_oe, 0);
  endtask

  task automatic t_ack(input bit upper);
    @(negedge clk); addr_hi = {FIX, sel_code}; addr_lo = '0; as_n = 0;
    after_edge(); after_edge(); after_edge();
    chk("R5 no strobe no ack", dtack_n, 1);
    @(negedge clk); if (upper) uds_n = 0; else lds_n = 0;
    after_edge();
    chk("R4 first edge", dtack_n, 1);
    after_edge();
    chk("R4 second edge", dtack_n, 0);
    @(negedge clk); as_n = 1; #1;
    chk("R6 async release", dtack_n, 1);
    @(negedge clk); as_n = 0;
    after_edge();
    chk("R6 restart first edge", dtack_n, 1);
    after_edge();
    chk("R6 restart second edge", dtack_n, 0);
    @(negedge clk); as_n = 1; uds_n = 1; lds_n = 1;
  endtask

  task automatic t_decode();
    @(negedge clk); addr_hi = {FIX, sel_code}; as_n = 0; lds_n = 0;
    for (int i = 0; i < 8; i++) begin
      addr_lo = 6'(i); #1;
      chk("R8 one-hot", reg_sel, 32'(1) << i);
      chk("R7 flag low", ana_rd, 0);
    end
    addr_lo = 6'b100101; #1;
    chk("R7 analog read", ana_rd, 1);
    chk("R8 blocked by read", reg_sel, 0);
    lds_n = 1; addr_lo = 6'b000011; #1;
    chk("R8 no strobe", reg_sel, 0);
    as_n = 1; addr_lo = 6'b100000; #1;
    chk("R7 not addressed", ana_rd, 0);
  endtask

  task automatic t_gain();
    @(negedge clk); addr_hi = {FIX, sel_code}; as_n = 0; addr_lo = 6'b000000;
    after_edge(); after_edge(); after_edge();
    chk("R9 settle zero", gain, 0);
    @(negedge clk); addr_lo = 6'b011000;
    after_edge();
    chk("R9 one edge", gain, 0);
    after_edge();
    chk("R9 two edges", gain, 3);
    @(negedge clk); as_n = 1; addr_lo = 6'b001000;
    after_edge(); after_edge(); after_edge();
    chk("R9 hold while deselected", gain, 3);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_match();
    t_ack(1'b1);
    t_ack(1'b0);
    t_decode();
    t_gain();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule